// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge gives a processor access to registers that live in a slow, always-on domain, such as a real-time clock or power controller, without mapping them straight onto the processor bus. The processor stages each access in a small local register file. It writes a target address, an access-mode byte that holds per-lane enables and a write flag, and for writes a data word. It then sets a start bit. The bridge carries out exactly one request/acknowledge transaction toward the far-side target and finishes it when the target acknowledges.

The start bit also serves as the busy flag. It reads as one for the whole transaction and drops by itself one cycle after the acknowledge. Software polls it before staging the next access. Mode 0x00 performs a read, and the fetched word then sits in the data register. Mode 0xF1 writes the whole data word. Other codes give partial-lane writes. Local register offsets are: command 0x0, mode 0x4, target address 0x8, data 0xC.

Top module: `ind_reg_bridge`

## Requirements
- R1: After a synchronous reset, all four local registers read zero and far_req is low.
- R2: A write to offset 0x0 with bit 0 set while idle asserts far_req in the next cycle. From then on, offset 0x0 reads 1 until completion.
- R3: While far_req is high and far_ack is low, far_req stays high and far_addr, far_wdata and far_we stay stable.
- R4: far_ack seen with far_req high ends the transaction. In the next cycle far_req is low and offset 0x0 reads 0.
- R5: With mode bit 0 clear, the access is a read and far_we is zero. At completion the data register (0xC) holds far_rdata sampled with far_ack.
- R6: Mode 0xF1 writes the whole data register word to far_addr, with far_we all ones.
- R7: Lane i's far_we bit is high only when mode bit 0 and mode bit 4+i are both set. For example, 0x31 enables lanes 0 and 1, and 0x30 is a read.
- R8: While busy, writes to offsets 0x4, 0x8 and 0xC are ignored, and a further start request starts no second transaction.
- R9: A write transaction leaves the data register unchanged, whatever far_rdata carries.
- R10: A write to offset 0x0 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Local register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Byte offset of local register |
| cpu_wdata | input | 32 | Local write data |
| cpu_rdata | output | 32 | Local read data (combinational) |
| far_req | output | 1 | Far-side request, held until acknowledge |
| far_addr | output | 32 | Far-side register address |
| far_wdata | output | 32 | Far-side write data |
| far_we | output | 4 | Far-side per-lane write enables |
| far_wr | output | 1 | Far-side write flag (0 = read) |
| far_ack | input | 1 | Far-side acknowledge |
| far_rdata | input | 32 | Far-side read data, valid with far_ack |

## Verification
Full-word writes followed by read-back show that the write and read paths land at the same far-side address. Partial-lane codes, including a lane mask with the flag clear, separate the lane gating from the read/write choice. Accesses staged during a long acknowledge delay show whether busy-time writes and second starts are truly dropped. Junk read data on write completions exposes any wrong load of the data register. A seeded random mix of modes, addresses and acknowledge delays then runs against a shadow memory kept by the bench.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
   // Local register slots, decoded from cpu_addr[3:2]; software relies on these offsets
   localparam logic [1:0] SLOT_CMD  = 2'd0;
   localparam logic [1:0] SLOT_MODE = 2'd1;
   localparam logic [1:0] SLOT_ADDR = 2'd2;
   localparam logic [1:0] SLOT_DATA = 2'd3;

   // Mode byte layout
   localparam int WR_FLAG_BIT = 0;
   localparam int LANE_LSB    = 4;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } ibr_state_e;
endpackage

// File: rtl/ibr_lane_dec.sv
module ibr_lane_dec #(
   parameter int LANES  = 4,
   parameter int MODE_W = 8
) (
   input  logic [MODE_W-1:0] mode,
   output logic [LANES-1:0]  lane_we,
   output logic              is_write
);
   import ibr_pkg::*;

   if (LANE_LSB + LANES > MODE_W) begin : g_bad_mode_w
      $error("ibr_lane_dec: mode register too narrow for lane enables");
   end

   assign is_write = mode[WR_FLAG_BIT];

   // one gate per lane: write flag AND that lane's enable
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_we[i] = mode[WR_FLAG_BIT] & mode[LANE_LSB+i];
   end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic is_write,
   input  logic far_ack,
   output logic busy,
   output logic load_rd
);
   import ibr_pkg::*;

   ibr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start)   state_d = ST_WAIT;
         ST_WAIT: if (far_ack) state_d = ST_IDLE;
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign busy    = (state_q == ST_WAIT);
   assign load_rd = busy && far_ack && !is_write;
endmodule

// File: rtl/ibr_regs.sv
module ibr_regs #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        slot,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              load_rd,
   input  logic [DATA_W-1:0] rd_word,
   output logic              start,
   output logic [MODE_W-1:0] mode_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] rdata
);
   import ibr_pkg::*;

   if (ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ibr_regs: address register wider than data path");
   end
   if (MODE_W > DATA_W) begin : g_bad_mode_w
      $error("ibr_regs: mode register wider than data path");
   end

   // staging writes are taken only while idle
   logic stage_ok;
   assign stage_ok = wr_en && !busy;
   assign start    = stage_ok && (slot == SLOT_CMD) && wdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (stage_ok && slot == SLOT_MODE) mode_q <= wdata[MODE_W-1:0];
         if (stage_ok && slot == SLOT_ADDR) addr_q <= wdata[ADDR_W-1:0];
         if (load_rd)                         data_q <= rd_word;
         else if (stage_ok && slot == SLOT_DATA) data_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (slot)
         SLOT_CMD:  rdata[0]          = busy;
         SLOT_MODE: rdata[MODE_W-1:0] = mode_q;
         SLOT_ADDR: rdata[ADDR_W-1:0] = addr_q;
         SLOT_DATA: rdata             = data_q;
         default:   rdata             = '0;
      endcase
   end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [3:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              far_req,
   output logic [ADDR_W-1:0] far_addr,
   output logic [DATA_W-1:0] far_wdata,
   output logic [LANES-1:0]  far_we,
   output logic              far_wr,
   input  logic              far_ack,
   input  logic [DATA_W-1:0] far_rdata
);
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("ind_reg_bridge: DATA_W must be a whole number of bytes");
   end
   if (LANES * 8 != DATA_W) begin : g_bad_lanes
      $error("ind_reg_bridge: LANES must equal DATA_W/8");
   end

   logic              start, busy, load_rd, is_write;
   logic [MODE_W-1:0] mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   ibr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cpu_sel && cpu_wr),
      .slot    (cpu_addr[3:2]),
      .wdata   (cpu_wdata),
      .busy    (busy),
      .load_rd (load_rd),
      .rd_word (far_rdata),
      .start   (start),
      .mode_q  (mode_q),
      .addr_q  (addr_q),
      .data_q  (data_q),
      .rdata   (cpu_rdata)
   );

   ibr_lane_dec #(.LANES(LANES), .MODE_W(MODE_W)) u_lanes (
      .mode     (mode_q),
      .lane_we  (far_we),
      .is_write (is_write)
   );

   ibr_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .is_write (is_write),
      .far_ack  (far_ack),
      .busy     (busy),
      .load_rd  (load_rd)
   );

   assign far_req   = busy;
   assign far_addr  = addr_q;
   assign far_wdata = data_q;
   assign far_wr    = is_write;
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_sel,
   input logic              cpu_wr,
   input logic [3:0]        cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              far_req,
   input logic [ADDR_W-1:0] far_addr,
   input logic [DATA_W-1:0] far_wdata,
   input logic [LANES-1:0]  far_we,
   input logic              far_wr,
   input logic              far_ack
);
   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> !far_req);

   // R2
   start_req_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_sel && cpu_wr && cpu_addr[3:2] == 2'd0 && cpu_wdata[0] && !far_req |=> far_req);

   // R10
   no_start_chk: assert property (@(posedge clk) disable iff (rst)
      !far_req && !(cpu_sel && cpu_wr && cpu_addr[3:2] == 2'd0 && cpu_wdata[0]) |=> !far_req);

   // R3
   hold_req_chk: assert property (@(posedge clk) disable iff (rst)
      far_req && !far_ack |=> far_req && $stable(far_addr) && $stable(far_wdata) && $stable(far_we));

   // R4
   end_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
      far_req && far_ack |=> !far_req);

   // R5
   read_no_we_chk: assert property (@(posedge clk) disable iff (rst)
      far_req && !far_wr |-> far_we == '0);
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cpu_sel   (cpu_sel),
   .cpu_wr    (cpu_wr),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .far_req   (far_req),
   .far_addr  (far_addr),
   .far_wdata (far_wdata),
   .far_we    (far_we),
   .far_wr    (far_wr),
   .far_ack   (far_ack)
);

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
   logic [3:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0, cpu_rdata;
   logic        far_req, far_wr;
   logic [31:0] far_addr, far_wdata;
   logic [3:0]  far_we;
   logic        far_ack = 1'b0;
   logic [31:0] far_rdata = '0;

   int checks = 0, fails = 0, cycles = 0;
   int req_rises = 0;
   bit prev_req = 0;

   // far-side target memory and the bench's independent shadow
   logic [31:0] tgt_mem [16];
   logic [31:0] shadow  [16];
   int resp_delay = 2;
   bit resp_rand  = 0;
   int resp_cnt   = 0;

   always #2.5 clk = ~clk;

   ind_reg_bridge u_ind_reg_bridge (
      .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .far_req(far_req), .far_addr(far_addr),
      .far_wdata(far_wdata), .far_we(far_we), .far_wr(far_wr), .far_ack(far_ack),
      .far_rdata(far_rdata)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_lanes(logic [7:0] mode);
      return mode[0] ? mode[7:4] : 4'h0;
   endfunction

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] we);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (we[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   // far-side responder
   always @(negedge clk) begin
      if (far_ack) begin
         far_ack = 1'b0;
      end else if (far_req && !rst) begin
         if (resp_cnt >= resp_delay) begin
            resp_cnt = 0;
            far_ack  = 1'b1;
            if (far_wr) begin
               tgt_mem[far_addr[5:2]] = merge(tgt_mem[far_addr[5:2]], far_wdata, far_we);
               far_rdata = 32'hDEAD_BEEF;
            end else begin
               far_rdata = tgt_mem[far_addr[5:2]];
            end
            if (resp_rand) resp_delay = $urandom_range(0, 6);
         end else begin
            resp_cnt++;
         end
      end
   end

   // R4 monitor: one cycle after an accepted ack, the request is gone
   bit ack_seen = 0;
   always @(negedge clk) begin
      if (ack_seen) check("R4 far_req after ack", {31'd0, far_req}, 32'd0);
      ack_seen = far_req && far_ack && !rst;
   end

   always @(posedge clk) begin
      if (far_req && !prev_req) req_rises++;
      prev_req <= far_req;
   end

   // watchdog
   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic cpu_write(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 0; cpu_wr = 0;
   endtask

   task automatic cpu_read(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
      #1 d = cpu_rdata;
      cpu_sel = 0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         cpu_read(4'h0, v);
         if (v == 0) return;
      end
      check("R4 completion", v, 32'd0);
   endtask

   task automatic do_write(logic [31:0] a, logic [31:0] d, logic [7:0] mode);
      wait_idle();
      cpu_write(4'h4, {24'd0, mode});
      cpu_write(4'h8, a);
      cpu_write(4'hC, d);
      cpu_write(4'h0, 32'd1);
      wait_idle();
      shadow[a[5:2]] = merge(shadow[a[5:2]], d, exp_lanes(mode));
   endtask

   task automatic do_read(logic [31:0] a, logic [7:0] mode, output logic [31:0] d);
      wait_idle();
      cpu_write(4'h4, {24'd0, mode});
      cpu_write(4'h8, a);
      cpu_write(4'h0, 32'd1);
      wait_idle();
      cpu_read(4'hC, d);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) begin
         tgt_mem[i] = 32'h1000_0000 + i;
         shadow[i]  = 32'h1000_0000 + i;
      end
      repeat (3) @(negedge clk);
      rst = 0;

      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         cpu_read(4'(s * 4), v);
         check("R1 reset register", v, 32'd0);
      end
      check("R1 far_req reset", {31'd0, far_req}, 32'd0);

      // R10 start bit clear does nothing
      cpu_write(4'h0, 32'h0000_0002);
      repeat (3) @(negedge clk);
      check("R10 no request", {31'd0, far_req}, 32'd0);
      check("R10 rise count", req_rises, 0);

      // R2 / R6 full write
      resp_delay = 3;
      cpu_write(4'h4, 32'hF1);
      cpu_write(4'h8, 32'h14);
      cpu_write(4'hC, 32'hCAFE_F00D);
      cpu_write(4'h0, 32'd1);
      check("R2 far_req after start", {31'd0, far_req}, 32'd1);
      check("R6 far_we full", {28'd0, far_we}, 32'hF);
      cpu_read(4'h0, v);
      check("R2 busy reads 1", v, 32'd1);
      wait_idle();
      shadow[5] = 32'hCAFE_F00D;
      check("R6 target word", tgt_mem[5], 32'hCAFE_F00D);
      // R9 data register kept despite junk far_rdata
      cpu_read(4'hC, v);
      check("R9 data kept after write", v, 32'hCAFE_F00D);

      // R5 read back
      do_read(32'h14, 8'h00, v);
      check("R5 read word", v, 32'hCAFE_F00D);

      // R7 partial lanes
      do_write(32'h20, 32'hAABB_CCDD, 8'h31);
      check("R7 lanes 0/1 write", tgt_mem[8], 32'h1000_CCDD);
      tgt_mem[9] = 32'h5555_6666; shadow[9] = 32'h5555_6666;
      do_read(32'h24, 8'h30, v);
      check("R7 flag clear is read", v, 32'h5555_6666);
      check("R7 target untouched", tgt_mem[9], 32'h5555_6666);

      // R8 busy-time writes ignored
      resp_delay = 12;
      wait_idle();
      cpu_write(4'h4, 32'hF1);
      cpu_write(4'h8, 32'h30);
      cpu_write(4'hC, 32'h0123_4567);
      v = req_rises;
      cpu_write(4'h0, 32'd1);
      cpu_write(4'hC, 32'hFFFF_FFFF);
      cpu_write(4'h8, 32'h34);
      cpu_write(4'h4, 32'h00);
      cpu_write(4'h0, 32'd1);
      wait_idle();
      repeat (4) @(negedge clk);
      check("R8 single transaction", req_rises, v + 1);
      check("R8 target word", tgt_mem[12], 32'h0123_4567);
      check("R8 untouched neighbour", tgt_mem[13], 32'h1000_000D);
      shadow[12] = 32'h0123_4567;
      cpu_read(4'hC, v);
      check("R8 data reg", v, 32'h0123_4567);
      cpu_read(4'h8, v);
      check("R8 addr reg", v, 32'h30);
      cpu_read(4'h4, v);
      check("R8 mode reg", v, 32'hF1);

      // random mix
      resp_rand = 1;
      for (int n = 0; n < 60; n++) begin
         logic [31:0] a, d;
         logic [7:0]  m;
         a = {26'd0, 4'($urandom_range(0, 15)), 2'b00};
         d = $urandom;
         case ($urandom_range(0, 2))
            0: m = 8'h00;
            1: m = 8'hF1;
            default: m = {4'($urandom), 3'd0, 1'($urandom)};
         endcase
         if (m[0]) begin
            do_write(a, d, m);
            cpu_read(4'hC, v);
            check("R9 random write keeps data", v, d);
         end else begin
            do_read(a, m, v);
            check("R5 random read", v, shadow[a[5:2]]);
         end
      end
      for (int i = 0; i < 16; i++) check("R7 final target image", tgt_mem[i], shadow[i]);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule